// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Cascaded Step Prescalers

This block drives four independent pulse-width-modulated outputs from one clock. Software programs it through a plain register port with a write strobe, a byte address, write data and combinational read data. A shared control word holds one enable bit and one 2-bit step-divider code per channel. Each channel also has its own configuration word, which holds an 8-bit timebase and an 8-bit duty count. Both counts are measured in step periods.

Each channel makes its step tick with two cascaded prescaler stages. The first divides by 8 and the second by 64. The divider code bypasses both stages, selects either stage alone, or chains them for a divide by 512. One output period lasts timebase steps. The output is high for the first duty steps of the period and low for the rest. A new timebase or duty value takes effect only when the running period ends, so a reprogrammed output never shows a cut-short pulse.

Top module: `quad_pwm`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: The control word is at byte offset 0x0. Bit n enables channel n. Bits [2n+5:2n+4] hold the divider code of channel n. Bits 11:0 read back as written, and bits 31:12 read zero.
- R3: The configuration word of channel n is at byte offset 0x4+4n. It holds the timebase in bits 7:0 and the duty in bits 23:16, and both fields read back as written. Every other bit reads zero. A write to an offset of 0x14 or above changes no register.
- R4: Divider code 0 gives a step of 1 clock cycle, code 1 gives 8 cycles, code 2 gives 64 cycles and code 3 gives 512 cycles.
- R5: An enabled channel repeats a period of timebase steps. Its output is high for the first duty steps of each period and low for the rest. The first period begins in the cycle right after the write that sets the enable bit.
- R6: A duty of 0 keeps the output low. A duty equal to or greater than the timebase keeps the output high.
- R7: A timebase of 0 keeps the output low while the channel is enabled.
- R8: When the enable bit of a channel is cleared, its output goes low from the next cycle and its counters are held cleared. Enabling the channel again starts a fresh period.
- R9: A new timebase or duty written while a channel runs takes effect only at the next period boundary. The period in progress finishes with its old values.
- R10: The four channels run concurrently, each with its own settings, and do not disturb one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers, prescalers and counters |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 5 | Byte address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| pwmOut | output | 4 | One modulated output per channel |

## Verification
The assertions assume that `addr` and `wrData` are valid whenever `wrEn` is high. They also assume that the low two address bits do not select anything: the readback properties decode only the word index. The bench keeps to these rules by driving every input on the falling clock edge and raising `wrEn` for exactly one cycle per write, always with a word-aligned address. The bench also writes all divider codes and configuration words while a channel is disabled, except in the test that changes settings mid-period. That way the period-start property for rising outputs always sees a clean starting point.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
  localparam int NCH  = 4;
  localparam int TB_W = 8;

  typedef struct packed {
    logic            en;
    logic [1:0]      divSel;
    logic [TB_W-1:0] tb;
    logic [TB_W-1:0] duty;
  } chanCfg_t;
endpackage

// File: rtl/quad_pwm_ctrl.sv
module quad_pwm_ctrl
  import quad_pwm_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int DUTY_LSB = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output chanCfg_t [NCH-1:0]    cfgVec
);
  localparam int IDX_W   = ADDR_W - 2;
  localparam int DIV_LSB = NCH;
  localparam int CTRL_W  = NCH * 3;

  logic [CTRL_W-1:0] ctrlReg;
  logic [TB_W-1:0]   tbReg   [NCH];
  logic [TB_W-1:0]   dutyReg [NCH];
  logic [IDX_W-1:0]  wordIdx;

  assign wordIdx = addr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0;
      for (int ch = 0; ch < NCH; ch++) begin
        tbReg[ch]   <= '0;
        dutyReg[ch] <= '0;
      end
    end else if (wrEn) begin
      if (wordIdx == '0) ctrlReg <= wrData[CTRL_W-1:0];
      for (int ch = 0; ch < NCH; ch++) begin
        if (wordIdx == IDX_W'(ch + 1)) begin
          tbReg[ch]   <= wrData[TB_W-1:0];
          dutyReg[ch] <= wrData[DUTY_LSB +: TB_W];
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (wordIdx == '0) rdData[CTRL_W-1:0] = ctrlReg;
    for (int ch = 0; ch < NCH; ch++) begin
      if (wordIdx == IDX_W'(ch + 1)) begin
        rdData[TB_W-1:0]          = tbReg[ch];
        rdData[DUTY_LSB +: TB_W]  = dutyReg[ch];
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cfg
    assign cfgVec[ch].en     = ctrlReg[ch];
    assign cfgVec[ch].divSel = ctrlReg[DIV_LSB + 2*ch +: 2];
    assign cfgVec[ch].tb     = tbReg[ch];
    assign cfgVec[ch].duty   = dutyReg[ch];
  end
endmodule

// File: rtl/quad_pwm_chan.sv
module quad_pwm_chan
  import quad_pwm_pkg::*;
#(
  parameter int PRE_A = 8,
  parameter int PRE_B = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  chanCfg_t cfg,
  output logic     pwmOut,
  output logic     atStart
);
  localparam int A_W = $clog2(PRE_A);
  localparam int B_W = $clog2(PRE_B);

  logic [A_W-1:0]  aCnt;
  logic [B_W-1:0]  bCnt;
  logic [TB_W-1:0] stepCnt, actTb, actDuty;
  logic            aWrap, bWrap, aTick, stepTick, lastStep;

  assign aWrap    = (aCnt == A_W'(PRE_A - 1));
  assign bWrap    = (bCnt == B_W'(PRE_B - 1));
  assign aTick    = cfg.divSel[0] ? aWrap : 1'b1;
  assign stepTick = cfg.divSel[1] ? (aTick && bWrap) : aTick;
  assign lastStep = (actTb == '0) || (stepCnt == actTb - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aCnt    <= '0;
      bCnt    <= '0;
      stepCnt <= '0;
      actTb   <= '0;
      actDuty <= '0;
    end else if (!cfg.en) begin
      aCnt    <= '0;
      bCnt    <= '0;
      stepCnt <= '0;
      actTb   <= cfg.tb;
      actDuty <= cfg.duty;
    end else begin
      if (cfg.divSel[0]) aCnt <= aWrap ? '0 : aCnt + 1'b1;
      if (cfg.divSel[1] && aTick) bCnt <= bWrap ? '0 : bCnt + 1'b1;
      if (stepTick) begin
        if (lastStep) begin
          stepCnt <= '0;
          actTb   <= cfg.tb;
          actDuty <= cfg.duty;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
    end
  end

  assign pwmOut  = cfg.en && (actTb != '0) && (stepCnt < actDuty);
  assign atStart = (stepCnt == '0);
endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import quad_pwm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NCH-1:0]    pwmOut
);
  chanCfg_t [NCH-1:0] cfgVec;
  logic     [NCH-1:0] atStart;

  quad_pwm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cfgVec(cfgVec)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    quad_pwm_chan chan_i (
      .clk(clk), .rst_n(rst_n), .cfg(cfgVec[ch]),
      .pwmOut(pwmOut[ch]), .atStart(atStart[ch])
    );
  end
endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk
  import quad_pwm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input chanCfg_t [NCH-1:0] cfgVec,
  input logic [NCH-1:0]     atStart,
  input logic [NCH-1:0]     pwmOut
);
  localparam int IDX_W = ADDR_W - 2;

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && (addr[ADDR_W-1:2] > IDX_W'(NCH)) |=> $stable(cfgVec)); // R3

  for (genvar i = 0; i < NCH; i++) begin : g_ast
    AST_CTRL_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wrEn && (addr[ADDR_W-1:2] == '0) |=> cfgVec[i].en == $past(wrData[i])); // R2
    AST_CTRL_DIV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wrEn && (addr[ADDR_W-1:2] == '0) |=> cfgVec[i].divSel == $past(wrData[NCH+2*i +: 2])); // R2
    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wrEn && (addr[ADDR_W-1:2] == IDX_W'(i + 1)) |=>
        (cfgVec[i].tb == $past(wrData[TB_W-1:0])) && (cfgVec[i].duty == $past(wrData[16 +: TB_W]))); // R3
    AST_RISE_AT_PERIOD_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwmOut[i]) |-> atStart[i]); // R9
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfgVec[i].en) |=> atStart[i]); // R8
  end
endmodule

bind quad_pwm quad_pwm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .cfgVec(cfgVec), .atStart(atStart), .pwmOut(pwmOut)
);

// File: tb/quad_pwm_tb_top.sv
module quad_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  pwmOut;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  quad_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // returns at the falling edge just after the register took the write
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  function automatic logic [31:0] cfgWord(input int tb, input int duty);
    return (32'(duty) << 16) | 32'(tb);
  endfunction

  // sample a channel for n cycles; expected high when (k%period) < highLen
  task automatic expectPattern(input string req, input int ch, input int n,
                               input int period, input int highLen, input int offset);
    int errs = 0;
    for (int k = 0; k < n; k++) begin
      logic e;
      e = (period == 0) ? 1'b0 : (((k + offset) % period) < highLen);
      if (pwmOut[ch] !== e) errs++;
      @(negedge clk);
    end
    check(req, errs, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      rd(5'(i*4), d);
      check("R1 register clear", d, 0);
    end
    check("R1 outputs low", pwmOut, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, d); check("R2 control readback", d, 32'h0000_0FFF);
    wr(5'h00, 32'h0000_0A5C);
    rd(5'h00, d); check("R2 control pattern", d, 32'h0000_0A5C);
    wr(5'h00, 0);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, d); check("R3 config readback", d, 32'h00FF_00FF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h00, d); check("R3 unmapped write leaves control", d, 0);
    for (int i = 0; i < 4; i++) begin
      rd(5'(4 + 4*i), d);
      check("R3 unmapped write leaves config", d, (i == 1) ? 32'h00FF_00FF : 0);
    end
    wr(5'h08, 0);
  endtask

  task automatic t_basic();
    wr(5'h04, cfgWord(10, 5));
    wr(5'h00, 32'h1);
    expectPattern("R5 tb10 duty5 divide1", 0, 30, 10, 5, 0);
    wr(5'h00, 0);
    expectPattern("R8 output low after disable", 0, 12, 0, 0, 0);
  endtask

  task automatic t_div();
    for (int sel = 1; sel < 4; sel++) begin
      int step = 1 << (3*sel);
      wr(5'h0C, cfgWord(4, 1));
      wr(5'h00, (32'h1 << 2) | (32'(sel) << 8));
      expectPattern("R4 divider code step length", 2, 8*step, 4*step, step, 0);
      wr(5'h00, 0);
    end
  endtask

  task automatic t_extremes();
    wr(5'h08, cfgWord(6, 0));
    wr(5'h00, 32'h2);
    expectPattern("R6 duty zero low", 1, 14, 0, 0, 0);
    wr(5'h00, 0);
    wr(5'h08, cfgWord(6, 6));
    wr(5'h00, 32'h2);
    expectPattern("R6 duty equals timebase high", 1, 14, 1, 1, 0);
    wr(5'h00, 0);
    wr(5'h08, cfgWord(6, 9));
    wr(5'h00, 32'h2);
    expectPattern("R6 duty above timebase high", 1, 14, 1, 1, 0);
    wr(5'h00, 0);
    wr(5'h08, cfgWord(0, 5));
    wr(5'h00, 32'h2);
    expectPattern("R7 timebase zero low", 1, 14, 0, 0, 0);
    wr(5'h00, 0);
  endtask

  task automatic t_restart();
    wr(5'h10, cfgWord(8, 3));
    wr(5'h00, 32'h8);
    expectPattern("R5 channel3 first cycles", 3, 5, 8, 3, 0);
    wr(5'h00, 0);
    expectPattern("R8 disabled mid-period low", 3, 10, 0, 0, 0);
    wr(5'h00, 32'h8);
    expectPattern("R8 restart at period start", 3, 24, 8, 3, 0);
    wr(5'h00, 0);
  endtask

  task automatic t_update();
    wr(5'h04, cfgWord(10, 5));
    wr(5'h00, 32'h1);
    // write occupies cycles 0..1; sampling resumes at cycle 2
    wr(5'h04, cfgWord(4, 1));
    expectPattern("R9 running period keeps old values", 0, 8, 10, 5, 2);
    expectPattern("R9 new values from next period", 0, 16, 4, 1, 0);
    wr(5'h00, 0);
  endtask

  task automatic t_multi();
    int errs = 0;
    wr(5'h04, cfgWord(5, 2));
    wr(5'h08, cfgWord(3, 3));
    wr(5'h0C, cfgWord(7, 0));
    wr(5'h10, cfgWord(0, 4));
    wr(5'h00, 32'h0000_001F);
    for (int k = 0; k < 120; k++) begin
      logic [3:0] e;
      e = {1'b0, 1'b0, 1'b1, ((k % 40) < 16)};
      if (pwmOut !== e) errs++;
      @(negedge clk);
    end
    check("R10 four channels concurrently", errs, 0);
    wr(5'h00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_basic();
    t_div();
    t_extremes();
    t_restart();
    t_update();
    t_multi();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule